// File: doc/BRIEF.md
# Masked-Access GPIO Port Controller

An eight-pin general-purpose I/O port controlled over a simple memory-mapped register bus. Software sets each pin's direction and output value. Software can also hand a pin's output and output enable to an on-chip peripheral. Each pin can be configured to raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. The port drives a single interrupt line to the system.

Accesses to the data window use address bits [9:2] as a per-pin mask. Software can therefore set, clear or read any subset of pins in one bus cycle, with no read-modify-write sequence. Pin inputs pass through a two-flop synchroniser before any detection or readback. Edge events are latched until software clears them with a write-one-to-clear register. Level events follow the pin and are not latched.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0. Every pin is therefore an input with `pin_oe_o` = 0 and `irq_o` = 0.
- R2: A write at a byte address in 0x000–0x3FC uses address bits [9:2] as a pin mask. Output bit i takes wdata bit i only when mask bit i is 1. All other output bits keep their value.
- R3: A read at a byte address in 0x000–0x3FC returns the synchronised pin levels ANDed with the mask in address bits [9:2]. All other read bits are 0.
- R4: Direction register at 0x400: bit 1 drives the pin (`pin_oe_o` = 1) and bit 0 makes it an input. Under register control, `pin_o` carries the data register.
- R5: Peripheral-select register at 0x420: bit 1 routes `periph_out_i` and `periph_oe_i` to `pin_o` and `pin_oe_o` for that pin. Bit 0 keeps the pin under register control.
- R6: When the sense bit (register 0x404) is 0, the pin is in edge mode. With the both-edges bit (0x408) at 0, the event bit (0x40C) chooses the edge: 1 means rising, 0 means falling. A detected edge sets the raw status bit (0x414), which stays set until cleared.
- R7: With the both-edges bit at 1 in edge mode, either transition sets the raw status bit, whatever the event bit holds.
- R8: When the sense bit is 1, the pin is in level mode. The raw status bit equals the synchronised pin level when the event bit is 1, and its inverse when the event bit is 0. The bit is not latched.
- R9: Masked status (0x418) is raw status ANDed with the enable register (0x410), where 1 means unmasked. `irq_o` is the OR of all masked status bits.
- R10: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge. Writing 0 leaves it unchanged.
- R11: If a new edge and a clear reach the same pin in the same cycle, the edge wins and the raw bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable, one access per cycle |
| re_i | input | 1 | Read enable; `rdata_o` is 0 when low |
| rdata_o | output | 32 | Read data, combinational from address |
| pin_i | input | 8 | Pad input levels (asynchronous) |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| periph_out_i | input | 8 | Peripheral output values |
| periph_oe_i | input | 8 | Peripheral output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some checks run on every cycle. Assertions check that a latched edge is held until a clear removes it, and that a clear without a coincident edge empties the latch. They also check that a coincident edge beats the clear, that masked data writes leave unselected output bits untouched, that input pins never drive, and that the interrupt is silent with every enable at zero. Other behaviour needs the bench's scenarios to show it. These scenarios are the edge polarity and both-edge choice, level tracking that drops when the pin returns, the masked readback of pin values through the synchroniser, and the peripheral hand-over per pin. The bench drives random data, masks and pin patterns alongside directed interrupt sequences.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 12;

  typedef enum logic [3:0] {
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_IE,
    SEL_RAW,
    SEL_MIS,
    SEL_CLR,
    SEL_AFSEL,
    SEL_NONE
  } reg_sel_e;

  // 0x000-0x3FC data window, 0x400-0x420 control block
  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (addr[11:10] == 2'b00) begin
      sel = SEL_DATA;
    end else if (addr[11:10] == 2'b01) begin
      case (addr[9:2])
        8'h00:   sel = SEL_DIR;
        8'h01:   sel = SEL_SENSE;
        8'h02:   sel = SEL_BOTH;
        8'h03:   sel = SEL_EVENT;
        8'h04:   sel = SEL_IE;
        8'h05:   sel = SEL_RAW;
        8'h06:   sel = SEL_MIS;
        8'h07:   sel = SEL_CLR;
        8'h08:   sel = SEL_AFSEL;
        default: sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_s_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] raw_o
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] edge_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] level_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_s_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = pin_s_i[g] & ~prev_q[g];
    assign fall = ~pin_s_i[g] & prev_q[g];
    assign hit[g] = both_i[g] ? (rise | fall) : (event_i[g] ? rise : fall);

    // R6: latched edge survives until cleared
    a_r6_edge_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_q[g] && !clr_i[g]) |=> edge_q[g]);
    // R10: clear without coincident edge empties the latch
    a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !(hit[g] && !sense_i[g])) |=> !edge_q[g]);
    // R11: new edge beats clear
    a_r11_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[g] && !sense_i[g]) |=> edge_q[g]);
  end

  // edge wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= '0;
    else         edge_q <= (edge_q & ~clr_i) | (hit & ~sense_i);
  end

  assign level_act = ~(pin_s_i ^ event_i);
  assign raw_o     = (sense_i & level_act) | (~sense_i & edge_q);

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] sel_periph_i,
  input  logic [NUM_PINS-1:0] reg_out_i,
  input  logic [NUM_PINS-1:0] reg_oe_i,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mux
    assign pin_o[g]    = sel_periph_i[g] ? periph_out_i[g] : reg_out_i[g];
    assign pin_oe_o[g] = sel_periph_i[g] ? periph_oe_i[g]  : reg_oe_i[g];
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] periph_oe_i,
  output logic                irq_o
);

  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] wval;
  logic                unused_wdata;

  logic [NUM_PINS-1:0] data_q, dir_q, sense_q, both_q, event_q, ie_q, afsel_q;
  logic [NUM_PINS-1:0] pin_s, raw, mis, clr;
  logic [NUM_PINS-1:0] rd_val;

  assign sel          = decode_addr(addr_i);
  assign mask         = addr_i[2 +: NUM_PINS];
  assign wval         = wdata_i[NUM_PINS-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
      afsel_q <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_DATA:  data_q  <= (data_q & ~mask) | (wval & mask);
        SEL_DIR:   dir_q   <= wval;
        SEL_SENSE: sense_q <= wval;
        SEL_BOTH:  both_q  <= wval;
        SEL_EVENT: event_q <= wval;
        SEL_IE:    ie_q    <= wval;
        SEL_AFSEL: afsel_q <= wval;
        default:   ;
      endcase
    end
  end

  assign clr = (we_i && sel == SEL_CLR) ? wval : '0;

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  gpio_irq_unit #(
    .NUM_PINS (NUM_PINS)
  ) i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_s_i (pin_s),
    .sense_i (sense_q),
    .both_i  (both_q),
    .event_i (event_q),
    .clr_i   (clr),
    .raw_o   (raw)
  );

  gpio_out_mux #(
    .NUM_PINS (NUM_PINS)
  ) i_mux (
    .sel_periph_i (afsel_q),
    .reg_out_i    (data_q),
    .reg_oe_i     (dir_q),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

  assign mis   = raw & ie_q;
  assign irq_o = |mis;

  always_comb begin
    case (sel)
      SEL_DATA:  rd_val = pin_s & mask;
      SEL_DIR:   rd_val = dir_q;
      SEL_SENSE: rd_val = sense_q;
      SEL_BOTH:  rd_val = both_q;
      SEL_EVENT: rd_val = event_q;
      SEL_IE:    rd_val = ie_q;
      SEL_RAW:   rd_val = raw;
      SEL_MIS:   rd_val = mis;
      SEL_AFSEL: rd_val = afsel_q;
      default:   rd_val = '0;
    endcase
  end

  assign rdata_o = re_i ? {{PAD_W{1'b0}}, rd_val} : '0;

  // R2: unmasked output bits keep their value
  a_r2_unmasked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_DATA) |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));
  // R4: register-controlled input pins never drive
  a_r4_input_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~afsel_q & ~dir_q) == '0);
  // R9: no interrupt with every enable clear
  a_r9_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);

endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_EVENT = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414,
                          A_MIS = 12'h418, A_CLR = 12'h41C, A_AFSEL = 12'h420;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pin_i = '0, pin_o, pin_oe_o;
  logic [7:0]  periph_out_i = '0, periph_oe_i = '0;
  logic        irq_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .periph_out_i, .periph_oe_i, .irq_o
  );

  function automatic logic [7:0] masked_write(logic [7:0] old, logic [7:0] v, logic [7:0] m);
    return (old & ~m) | (v & m);
  endfunction

  function automatic logic [7:0] mux_sel(logic [7:0] s, logic [7:0] a, logic [7:0] b);
    return (s & a) | (~s & b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    re_i = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  exp_data, afsel, pout, poe;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 pin_oe_o", {24'h0, pin_oe_o}, 32'h0);
    chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    rd(A_DIR, r);   chk("R1 dir", r, 32'h0);
    rd(A_EVENT, r); chk("R1 event", r, 32'h0);
    rd(A_AFSEL, r); chk("R1 afsel", r, 32'h0);
    rd(A_RAW, r);   chk("R1 raw", r, 32'h0);

    // R4 direction
    wr(A_DIR, 32'h3C);
    chk("R4 oe", {24'h0, pin_oe_o}, 32'h3C);
    wr(A_DIR, 32'hFF);
    chk("R4 oe all", {24'h0, pin_oe_o}, 32'hFF);

    // R2 masked data writes
    wr(12'h3FC, 32'hA5);
    exp_data = 8'hA5;
    chk("R2 full mask", {24'h0, pin_o}, {24'h0, exp_data});
    wr({2'b00, 8'h0F, 2'b00}, 32'hFFFF_FF00);
    exp_data = 8'hA0;
    chk("R2 low nibble cleared", {24'h0, pin_o}, {24'h0, exp_data});
    wr(12'h000, 32'hFF);
    chk("R2 empty mask", {24'h0, pin_o}, {24'h0, exp_data});
    for (int i = 0; i < 24; i++) begin
      logic [7:0] m, v;
      m = 8'($urandom); v = 8'($urandom);
      wr({2'b00, m, 2'b00}, {24'h0, v});
      exp_data = masked_write(exp_data, v, m);
      chk("R2 random", {24'h0, pin_o}, {24'h0, exp_data});
    end

    // R5 peripheral hand-over
    for (int i = 0; i < 12; i++) begin
      afsel = 8'($urandom); pout = 8'($urandom); poe = 8'($urandom);
      if (i == 0) begin afsel = 8'h0F; pout = 8'h55; poe = 8'h03; end
      periph_out_i = pout; periph_oe_i = poe;
      wr(A_AFSEL, {24'h0, afsel});
      chk("R5 pin_o", {24'h0, pin_o}, {24'h0, mux_sel(afsel, pout, exp_data)});
      chk("R5 pin_oe_o", {24'h0, pin_oe_o}, {24'h0, mux_sel(afsel, poe, 8'hFF)});
    end
    wr(A_AFSEL, 32'h0);
    wr(A_DIR, 32'h0);

    // R3 masked readback
    set_pins(8'hC3);
    rd({2'b00, 8'hF0, 2'b00}, r);
    chk("R3 directed", r, 32'hC0);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] p, m;
      p = 8'($urandom); m = 8'($urandom);
      set_pins(p);
      rd({2'b00, m, 2'b00}, r);
      chk("R3 random", r, {24'h0, p & m});
    end

    // interrupt configuration
    // pin0 falling, pin1 rising, pin2 both, pin3 level high, pin4 level low
    set_pins(8'h00);
    wr(A_SENSE, 32'h18);
    wr(A_EVENT, 32'h0A);
    wr(A_BOTH, 32'h04);
    wr(A_CLR, 32'hFF);
    @(negedge clk_i);
    rd(A_RAW, r); chk("R8 low level active", r, 32'h10);

    set_pins(8'h0F);
    rd(A_RAW, r); chk("R6 R7 R8 rise pattern", r, 32'h1E);

    set_pins(8'h00);
    rd(A_RAW, r); chk("R6 fall latched R8 level dropped", r, 32'h17);

    set_pins(8'h10);
    rd(A_RAW, r); chk("R8 low level released", r, 32'h07);

    // R9 masking and interrupt line
    wr(A_IE, 32'h05);
    rd(A_MIS, r); chk("R9 masked", r, 32'h05);
    chk("R9 irq set", {31'h0, irq_o}, 32'h1);
    wr(A_IE, 32'h00);
    rd(A_MIS, r); chk("R9 all masked", r, 32'h0);
    chk("R9 irq clear", {31'h0, irq_o}, 32'h0);
    wr(A_IE, 32'h02);
    chk("R9 irq single", {31'h0, irq_o}, 32'h1);

    // R10 write-one-to-clear
    wr(A_CLR, 32'h01);
    rd(A_RAW, r); chk("R10 clear one", r, 32'h06);
    wr(A_CLR, 32'h00);
    rd(A_RAW, r); chk("R10 zero no effect", r, 32'h06);
    wr(A_CLR, 32'hFF);
    rd(A_RAW, r); chk("R10 clear all", r, 32'h00);
    chk("R10 irq dropped", {31'h0, irq_o}, 32'h0);

    // R11 rising edge on pin1 coincides with its clear
    @(negedge clk_i); pin_i = 8'h12;
    @(negedge clk_i);
    @(negedge clk_i);
    addr_i = A_CLR; wdata_i = 32'h02; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    rd(A_RAW, r); chk("R11 edge beats clear", r, 32'h02);
    chk("R11 irq", {31'h0, irq_o}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule